// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked front end for an external 128K x 8 static RAM that has no clock of its own. The memory side has three active-low strobes (select, write, output enable), an address bus and an 8-bit data bus. The data bus is split into an output value, an output enable and an input value, so that a pad ring or a bench model can be attached. On the user side, single-byte read and write requests are taken with a valid/ready handshake. A read returns its byte together with a one-cycle valid strobe.

Every memory-side wait is measured in whole clock cycles. Each wait is found at elaboration by rounding a nanosecond limit up by the clock period. The speed-grade parameter (7, 8, 10 or 12 ns) sets these limits:

- Address access time: equal to the grade.
- Output-enable access time: 3, 3.5, 4 or 5 ns.
- Output-disable float time: 3, 3.5, 4 or 5 ns.
- Write strobe width: taken equal to the grade.

After every read, a turnaround interval keeps the controller's data drivers off until the memory has released the bus.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, until a request is accepted, the select, write and output-enable strobes are all high, the data drivers are off, ready is high and read-valid is low.
- R2: While a read is in progress, select and output enable are low, write is high, the data drivers are off and the address pins carry the requested address.
- R3: A read holds output enable low for exactly RD_CYC = ceil(max(address access, output-enable access) / clock period) cycles, and it samples the bus at the end of the last of these cycles. Read-valid is high RD_CYC+1 cycles after the accepting edge. With a 10 ns grade and an 8 ns clock, RD_CYC is 2.
- R4: Read-valid is high for exactly one cycle per read.
- R5: A write has three phases, with output enable high throughout:
  - one setup cycle with select low, write high and the drivers on;
  - WP_CYC = ceil(grade time / clock period) cycles with write low;
  - one cycle with write high and the drivers still on.
- R6: The address and data pins do not change from the setup cycle of a write through its final cycle with write high.
- R7: After every read, output enable is high and the drivers are off for HZ_CYC = ceil(float time / clock period) cycles before ready returns. The drivers are never on while output enable is low. The drivers switch on no sooner than the float time (4 ns at the 10 ns grade) after output enable rises.
- R8: Ready is high only when the controller is idle, with select high. It returns RD_CYC+HZ_CYC+1 cycles after a read is accepted and WP_CYC+3 cycles after a write is accepted.
- R9: A read of any address returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle strobe with read byte |
| rd_data | output | DATA_W | Read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data returned by memory |

## Verification
The checker assumes that the requester changes req_valid and its fields only between clock edges. It also assumes that the memory model presents a read byte no later than the grade limits, so that a sample taken after RD_CYC cycles is settled. The bench keeps to these assumptions. It drives every request at a falling edge and holds it for one cycle. Its memory model puts out the stored byte only once both the address access time and the output-enable access time have passed. Before that it returns an unknown value, apart from the 3 ns after an address change, during which it keeps the old byte. An early sample therefore shows up as a wrong byte.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_WAIT, ST_TURN, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD
   } ctl_state_e;

   // address access limit, in picoseconds
   function automatic int acc_ps(input int grade_ns);
      return grade_ns * 1000;
   endfunction

   // output-enable access limit, in picoseconds
   function automatic int oea_ps(input int grade_ns);
      case (grade_ns)
         7:       return 3000;
         8:       return 3500;
         10:      return 4000;
         default: return 5000;
      endcase
   endfunction

   // output-disable float limit, in picoseconds
   function automatic int flt_ps(input int grade_ns);
      case (grade_ns)
         7:       return 3000;
         8:       return 3500;
         10:      return 4000;
         default: return 5000;
      endcase
   endfunction

   // ceiling division, never below one cycle
   function automatic int to_cyc(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
`timescale 1ns/1ps
module sram_ctl_cnt #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int CW     = 2,
   parameter int RD_CYC = 2,
   parameter int WP_CYC = 2,
   parameter int HZ_CYC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          cnt_zero,
   output ctl_state_e    state,
   output logic          accept,
   output logic          capture,
   output logic          cnt_load,
   output logic [CW-1:0] cnt_val
);
   localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
   localparam logic [CW-1:0] HZ_LD = CW'(HZ_CYC - 1);

   ctl_state_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      accept   = 1'b0;
      capture  = 1'b0;
      cnt_load = 1'b0;
      cnt_val  = '0;
      case (st_q)
         ST_IDLE: if (req_valid) begin
            accept = 1'b1;
            if (req_write) st_d = ST_WR_SETUP;
            else begin
               st_d     = ST_RD_WAIT;
               cnt_load = 1'b1;
               cnt_val  = RD_LD;
            end
         end
         ST_RD_WAIT: if (cnt_zero) begin
            capture  = 1'b1;
            st_d     = ST_TURN;
            cnt_load = 1'b1;
            cnt_val  = HZ_LD;
         end
         ST_TURN: if (cnt_zero) st_d = ST_IDLE;
         ST_WR_SETUP: begin
            st_d     = ST_WR_PULSE;
            cnt_load = 1'b1;
            cnt_val  = WP_LD;
         end
         ST_WR_PULSE: if (cnt_zero) st_d = ST_WR_HOLD;
         ST_WR_HOLD:  st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state = st_q;
endmodule

// File: rtl/sram_ctl_io.sv
`timescale 1ns/1ps
module sram_ctl_io #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= capture;
         if (capture) rd_data <= dq_i;
      end
   end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int SPEED_NS = 10,
   parameter int CLK_PS   = 8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   localparam int RD_CYC = to_cyc(max2(acc_ps(SPEED_NS), oea_ps(SPEED_NS)), CLK_PS);
   localparam int WP_CYC = to_cyc(acc_ps(SPEED_NS), CLK_PS);
   localparam int HZ_CYC = to_cyc(flt_ps(SPEED_NS), CLK_PS);
   localparam int MAX_C  = max2(RD_CYC, max2(WP_CYC, HZ_CYC));
   localparam int CW     = $clog2(MAX_C + 1);

   generate
      if (!(SPEED_NS == 7 || SPEED_NS == 8 || SPEED_NS == 10 || SPEED_NS == 12)) begin : g_bad_grade
         initial $fatal(1, "sram_ctl: unsupported speed grade %0d", SPEED_NS);
      end
      if (ADDR_W < 1 || DATA_W < 1 || CLK_PS < 1) begin : g_bad_shape
         initial $fatal(1, "sram_ctl: width or clock parameter out of range");
      end
   endgenerate

   ctl_state_e    state;
   logic          accept, capture, cnt_load, cnt_zero;
   logic [CW-1:0] cnt_val;

   sram_ctl_seq #(
      .CW(CW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .cnt_zero(cnt_zero), .state(state), .accept(accept), .capture(capture),
      .cnt_load(cnt_load), .cnt_val(cnt_val)
   );

   sram_ctl_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
   );

   sram_ctl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
      .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
      .req_addr(req_addr), .req_wdata(req_wdata), .dq_i(mem_dq_i),
      .addr_q(mem_addr), .wdata_q(mem_dq_o), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always_comb begin
      req_ready = (state == ST_IDLE);
      mem_ce_n  = (state == ST_IDLE) || (state == ST_TURN);
      mem_oe_n  = (state != ST_RD_WAIT);
      mem_we_n  = (state != ST_WR_PULSE);
      mem_dq_oe = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
   end
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int SPEED_NS = 10,
   parameter int CLK_PS   = 8000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic              mem_dq_oe
);
   localparam int RD_CYC = to_cyc(max2(acc_ps(SPEED_NS), oea_ps(SPEED_NS)), CLK_PS);

   logic [7:0] oe_run;
   always_ff @(posedge clk) begin
      if (!rst_n)             oe_run <= '0;
      else if (!mem_oe_n)     oe_run <= (oe_run == 8'hFF) ? oe_run : oe_run + 1'b1;
      else                    oe_run <= '0;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

   AST_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n)); // R2

   AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (oe_run == 8'(RD_CYC))); // R3

   AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R4

   AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n)); // R5

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o))); // R6

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe); // R7

   AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (!mem_dq_oe && !req_ready)); // R7

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n); // R8
endmodule

bind sram_ctl sram_ctl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPEED_NS(SPEED_NS), .CLK_PS(CLK_PS)
) u_sram_ctl_chk (.*);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int NW = 1 << AW;
   localparam int CLK_PS = 8000;
   localparam real T_ACC = 10.0;
   localparam real T_OEA = 4.0;
   localparam real T_FLT = 4.0;
   localparam real T_OH  = 3.0;
   localparam int RD = (10000 + CLK_PS - 1) / CLK_PS;
   localparam int WP = (10000 + CLK_PS - 1) / CLK_PS;
   localparam int HZ = (4000 + CLK_PS - 1) / CLK_PS;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] rd_data, mem_dq_o;
   logic [DW-1:0] mem_dq_i = 'z;
   logic [AW-1:0] mem_addr;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .SPEED_NS(10), .CLK_PS(CLK_PS)) i_sram_ctl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural memory
   logic [DW-1:0] mem [NW];
   realtime t_addr = 0, t_oe_fall = 0, t_oe_rise = -100, t_we_fall = 0;
   bit seen_read = 0;

   always @(mem_addr)        t_addr = $realtime;
   always @(negedge mem_oe_n) begin t_oe_fall = $realtime; seen_read = 1; end
   always @(posedge mem_oe_n) t_oe_rise = $realtime;
   always @(negedge mem_we_n) t_we_fall = $realtime;

   always @(posedge mem_we_n) if (rst_n && !mem_ce_n) begin
      chk(($realtime - t_we_fall) >= T_ACC, "R5 write strobe width",
          32'($rtoi($realtime - t_we_fall)), 32'($rtoi(T_ACC)));
      mem[mem_addr] = mem_dq_o;
   end

   always @(posedge mem_dq_oe) if (rst_n && seen_read)
      chk(($realtime - t_oe_rise) >= T_FLT, "R7 float before drive",
          32'($rtoi($realtime - t_oe_rise)), 32'($rtoi(T_FLT)));

   initial forever begin
      #0.1;
      if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1) begin
         if (($realtime - t_addr) >= T_ACC && ($realtime - t_oe_fall) >= T_OEA)
            mem_dq_i = mem[mem_addr];
         else if (($realtime - t_addr) >= T_OH)
            mem_dq_i = 'x;
      end else mem_dq_i = 'z;
   end

   task automatic wait_ready();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d);
      wait_ready();
      req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
      @(negedge clk); req_valid = 0;
      chk(!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe, "R5 setup pins",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0111);
      chk(mem_addr == AW'(a) && mem_dq_o == d, "R6 setup addr/data", {mem_addr, mem_dq_o}, {AW'(a), d});
      chk(!req_ready, "R8 busy during write", req_ready, 0);
      for (int k = 0; k < WP; k++) begin
         @(negedge clk);
         chk(!mem_we_n && mem_oe_n, "R5 strobe low", {mem_we_n, mem_oe_n}, 2'b01);
         chk(mem_addr == AW'(a) && mem_dq_o == d, "R6 addr/data stable", {mem_addr, mem_dq_o}, {AW'(a), d});
      end
      @(negedge clk);
      chk(mem_we_n && mem_dq_oe && !mem_ce_n && !req_ready, "R5 hold cycle",
          {mem_we_n, mem_dq_oe, mem_ce_n, req_ready}, 4'b1100);
      chk(mem_addr == AW'(a) && mem_dq_o == d, "R6 hold addr/data", {mem_addr, mem_dq_o}, {AW'(a), d});
      @(negedge clk);
      chk(req_ready && mem_ce_n && !mem_dq_oe, "R8 ready after write", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
   endtask

   task automatic do_read(input int a, input logic [DW-1:0] exp);
      wait_ready();
      req_valid = 1; req_write = 0; req_addr = AW'(a);
      @(negedge clk); req_valid = 0;
      for (int k = 1; k <= RD; k++) begin
         if (k > 1) @(negedge clk);
         chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == AW'(a),
             "R2 read pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
         chk(!rd_valid && !req_ready, "R3 no early valid", {rd_valid, req_ready}, 0);
      end
      @(negedge clk);
      chk(rd_valid, "R3 valid at RD+1", rd_valid, 1);
      chk(rd_data === exp, "R9 read data", rd_data, exp);
      chk(mem_oe_n && !mem_dq_oe && !req_ready, "R7 turnaround",
          {mem_oe_n, mem_dq_oe, req_ready}, 3'b100);
      for (int j = 1; j < HZ; j++) begin
         @(negedge clk);
         chk(!req_ready && !mem_dq_oe, "R7 turnaround hold", {req_ready, mem_dq_oe}, 0);
      end
      @(negedge clk);
      chk(!rd_valid, "R4 single pulse", rd_valid, 0);
      chk(req_ready, "R8 ready after read", req_ready, 1);
   endtask

   function automatic logic [DW-1:0] pat(input int i, input int s);
      return DW'(i * 37 + s * 91 + 5);
   endfunction

   initial begin
      for (int i = 0; i < NW; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 pins in reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle pins",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      chk(req_ready && !rd_valid, "R1 idle handshake", {req_ready, rd_valid}, 2'b10);
      for (int i = 0; i < NW; i++) do_write(i, pat(i, 0));
      for (int i = 0; i < NW; i++) do_read(i, pat(i, 0));
      // read directly followed by write, then read back, descending
      for (int i = NW - 1; i >= 0; i--) begin
         do_read(i, pat(i, 0));
         do_write(i, ~pat(i, 1));
         do_read(i, ~pat(i, 1));
      end
      for (int i = 0; i < NW; i += 7) do_read(i, ~pat(i, 1));
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         repeat (100000) @(posedge clk);
      join_any
      if (!finished) chk(0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule